// File: doc/BRIEF.md
# VID-Coded Reference Slew Controller

This block turns a 3-bit voltage-ID input into a reference target in millivolts and walks a reference DAC word toward that target at a fixed slew. The same limited ramp serves two purposes. It provides a soft start from zero, either after reset or whenever the run enable rises or a soft-start request arrives. It also moves the reference smoothly when the voltage ID is changed during operation, so the output of the downstream converter never sees a step.

The highest ID selects external-divider operation. In that mode the block raises a select line that routes the error-amplifier feedback to the external divider pin, and it ramps the reference to the fixed feedback level of 600 mV. The ID input is asynchronous. It passes through a synchroniser and must then hold steady for a number of samples before it is accepted as the new target. The DAC, the error amplifier and the PWM sit outside the block.

Top module: `vid_ref_slewer`

## Requirements
- R1: While reset is asserted and directly after it, `dac_mv` is 0, `ramp_done` is 0 and `fb_ext_sel` is 0. The accepted ID resets to 000.
- R2: The accepted ID selects the target in mV as follows: 000→3300, 001→2500, 010→1800, 011→1500, 100→1250, 101→1200, 110→800. The ramp settles exactly on that value.
- R3: The accepted ID 111 sets the target to 600 mV and drives `fb_ext_sel` high. Every other accepted ID drives `fb_ext_sel` low.
- R4: While the code differs from the target, it moves toward the target by `STEP_MV` once every `CYC_PER_STEP` clock cycles. It never changes by more than `STEP_MV` between two cycles, which also holds for live ID changes. A ramp of n steps that starts when `run_en` rises completes after n·`CYC_PER_STEP` cycles.
- R5: The code never passes the target. When the remaining distance is smaller than `STEP_MV`, the last step lands exactly on the target.
- R6: A one-cycle `soft_start` pulse sets the code to 0 at the next clock edge and lowers `ramp_done`. The ramp then restarts toward the current target.
- R7: While `run_en` is low, `dac_mv` reads 0 in the same cycle. When `run_en` rises, the code starts from 0 and ramps up.
- R8: An ID value must stay steady for `STABLE_CYC` consecutive synchronised samples before it is accepted. A glitch of three cycles or fewer leaves the target, `dac_mv`, `fb_ext_sel` and `ramp_done` unchanged.
- R9: `ramp_done` is high exactly when `run_en` is high and the code equals the target. It falls within `SYNC_STAGES`+`STABLE_CYC`+2 cycles of a new ID being applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid | input | 3 | Voltage ID; asynchronous to clk |
| soft_start | input | 1 | One-cycle request to restart the ramp from 0 |
| run_en | input | 1 | Run enable; low forces the code to 0 |
| dac_mv | output | 12 | Reference DAC code in mV |
| fb_ext_sel | output | 1 | High routes feedback to the external divider pin |
| ramp_done | output | 1 | Code has reached the target |

## Verification
Several properties are checked on every cycle. The code moves by at most one step per cycle. It never crosses a stable target. It starts from zero when run rises. The external-select line always pairs with the 600 mV target. A finished ramp stays finished while its target holds. Other behaviour is visible only in the bench scenarios: the exact table values, how long a ramp takes, and whether a short ID glitch is rejected. The same applies to the clamped final step under a step size that does not divide the distance, and to the drop of `ramp_done` on a new ID.

// File: rtl/vref_pkg.sv
package vref_pkg;
  localparam int MV_W  = 12;
  localparam int VID_W = 3;
  localparam logic [VID_W-1:0] VID_EXT = 3'b111;
  localparam logic [MV_W-1:0]  EXT_FB_MV = 12'd600;

  function automatic logic [MV_W-1:0] vid_to_mv(input logic [VID_W-1:0] v);
    logic [MV_W-1:0] mv;
    case (v)
      3'b000:  mv = 12'd3300;
      3'b001:  mv = 12'd2500;
      3'b010:  mv = 12'd1800;
      3'b011:  mv = 12'd1500;
      3'b100:  mv = 12'd1250;
      3'b101:  mv = 12'd1200;
      3'b110:  mv = 12'd800;
      default: mv = EXT_FB_MV;
    endcase
    return mv;
  endfunction
endpackage

// File: rtl/vref_vid_filter.sv
module vref_vid_filter
  import vref_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] vid_i,
  output logic [VID_W-1:0] vid_acc_o
);
  localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYC - 1);

  logic [VID_W-1:0] sync_q [SYNC_STAGES];
  logic [VID_W-1:0] hold_q, hold_d;
  logic [VID_W-1:0] acc_q, acc_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= '0;
        else        sync_q[0] <= vid_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= '0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    if (sync_q[SYNC_STAGES-1] != hold_q) begin
      hold_d = sync_q[SYNC_STAGES-1];
      cnt_d  = '0;
    end else if (cnt_q != CNT_LAST) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      acc_d = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
    end
  end

  assign vid_acc_o = acc_q;
endmodule

// File: rtl/vref_step_timer.sv
module vref_step_timer #(
  parameter int CYC_PER_STEP = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic tick_o
);
  localparam int CW = (CYC_PER_STEP > 1) ? $clog2(CYC_PER_STEP) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CYC_PER_STEP - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!active_i)              cnt_d = '0;
    else if (cnt_q == CNT_LAST) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = active_i && (cnt_q == CNT_LAST);
endmodule

// File: rtl/vref_ramp.sv
module vref_ramp
  import vref_pkg::*;
#(
  parameter int STEP_MV = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic [MV_W-1:0] tgt_i,
  output logic [MV_W-1:0] cur_o
);
  localparam logic [MV_W-1:0] STEP = MV_W'(STEP_MV);

  logic [MV_W-1:0] cur_q, cur_d;
  logic [MV_W-1:0] gap;
  logic            up;

  always_comb begin
    up  = tgt_i > cur_q;
    gap = up ? (tgt_i - cur_q) : (cur_q - tgt_i);
    cur_d = cur_q;
    if (clr_i) begin
      cur_d = '0;
    end else if (tick_i) begin
      if (gap <= STEP)  cur_d = tgt_i;
      else if (up)      cur_d = cur_q + STEP;
      else              cur_d = cur_q - STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/vid_ref_slewer.sv
module vid_ref_slewer
  import vref_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_CYC   = 4,
  parameter int CYC_PER_STEP = 50,
  parameter int STEP_MV      = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] vid,
  input  logic             soft_start,
  input  logic             run_en,
  output logic [MV_W-1:0]  dac_mv,
  output logic             fb_ext_sel,
  output logic             ramp_done
);
  logic [VID_W-1:0] vid_acc;
  logic [MV_W-1:0]  tgt_mv;
  logic [MV_W-1:0]  cur_mv;
  logic             moving;
  logic             clr;
  logic             tick;

  vref_vid_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .STABLE_CYC (STABLE_CYC)
  ) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .vid_i    (vid),
    .vid_acc_o(vid_acc)
  );

  assign tgt_mv     = vid_to_mv(vid_acc);
  assign fb_ext_sel = (vid_acc == VID_EXT);
  assign moving     = (cur_mv != tgt_mv);
  assign clr        = soft_start || !run_en;

  vref_step_timer #(
    .CYC_PER_STEP(CYC_PER_STEP)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active_i(moving && !clr),
    .tick_o  (tick)
  );

  vref_ramp #(
    .STEP_MV(STEP_MV)
  ) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .tick_i(tick),
    .tgt_i (tgt_mv),
    .cur_o (cur_mv)
  );

  assign dac_mv    = run_en ? cur_mv : '0;
  assign ramp_done = run_en && !moving;
endmodule

// File: rtl/vref_slew_chk.sv
module vref_slew_chk
  import vref_pkg::*;
#(
  parameter int STEP_MV = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            soft_start,
  input logic            run_en,
  input logic [MV_W-1:0] dac_mv,
  input logic            fb_ext_sel,
  input logic            ramp_done,
  input logic [MV_W-1:0] tgt_mv
);
  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && !$past(soft_start)) |->
      (((dac_mv >= $past(dac_mv)) ? (dac_mv - $past(dac_mv))
                                  : ($past(dac_mv) - dac_mv)) <= MV_W'(STEP_MV)));

  // R5
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && !$past(soft_start) && $stable(tgt_mv)) |->
      ((($past(dac_mv) > tgt_mv) || (dac_mv <= tgt_mv)) &&
       (($past(dac_mv) < tgt_mv) || (dac_mv >= tgt_mv))));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !$past(run_en)) |-> (dac_mv == '0));

  // R3
  ext_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_ext_sel |-> (tgt_mv == EXT_FB_MV));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_done && run_en && !soft_start) |=>
      (ramp_done || !run_en || (tgt_mv != $past(tgt_mv))));
endmodule

bind vid_ref_slewer vref_slew_chk #(.STEP_MV(STEP_MV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_start(soft_start),
  .run_en    (run_en),
  .dac_mv    (dac_mv),
  .fb_ext_sel(fb_ext_sel),
  .ramp_done (ramp_done),
  .tgt_mv    (tgt_mv)
);

// File: tb/vid_ref_slewer_test.sv
module vid_ref_slewer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CYC_A  = 2;
  localparam int STEP_B = 7;
  localparam int CYC_B  = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  vid;
  logic        soft_start;
  logic        run_en;
  logic [11:0] dac_a, dac_b;
  logic        ext_a, ext_b, done_a, done_b;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_ref_slewer #(.SYNC_STAGES(2), .STABLE_CYC(4), .CYC_PER_STEP(CYC_A), .STEP_MV(1)) uut (
    .clk(clk), .rst_n(rst_n), .vid(vid), .soft_start(soft_start), .run_en(run_en),
    .dac_mv(dac_a), .fb_ext_sel(ext_a), .ramp_done(done_a));

  vid_ref_slewer #(.SYNC_STAGES(2), .STABLE_CYC(4), .CYC_PER_STEP(CYC_B), .STEP_MV(STEP_B)) uut_s7 (
    .clk(clk), .rst_n(rst_n), .vid(vid), .soft_start(soft_start), .run_en(run_en),
    .dac_mv(dac_b), .fb_ext_sel(ext_b), .ramp_done(done_b));

  function automatic int mv_of(input int v);
    case (v)
      0: return 3300; 1: return 2500; 2: return 1800; 3: return 1500;
      4: return 1250; 5: return 1200; 6: return 800;  default: return 600;
    endcase
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  // Apply a new ID and follow both instances until they settle.
  task automatic go_vid(input int v);
    int t, sa, sb, pa, pb, n, cycles, drop_at, bad_a, bad_b, lo, hi;
    t  = mv_of(v);
    sa = dac_a; sb = dac_b; pa = sa; pb = sb;
    lo = (sa < t) ? sa : t; hi = (sa < t) ? t : sa;
    n  = iabs(t - sa);
    cycles = 0; drop_at = -1; bad_a = 0; bad_b = 0;
    vid = 3'(v);
    while (cycles < 20000) begin
      @(negedge clk); #1;
      cycles++;
      if (drop_at < 0 && !done_a) drop_at = cycles;
      if (iabs(int'(dac_a) - pa) > 1 || int'(dac_a) < lo || int'(dac_a) > hi) bad_a++;
      if (iabs(int'(dac_b) - pb) > STEP_B || int'(dac_b) < ((sb < t) ? sb : t)
          || int'(dac_b) > ((sb < t) ? t : sb)) bad_b++;
      pa = dac_a; pb = dac_b;
      if (drop_at >= 0 && done_a && done_b) break;
    end
    // R9 done falls soon after a new ID
    check(drop_at >= 1 && drop_at <= 8, "R9 done drop", drop_at, 7);
    // R2 / R3 settled value
    check(int'(dac_a) == t, (v == 7) ? "R3 ext target" : "R2 preset target", dac_a, t);
    check(ext_a == (v == 7), "R3 fb_ext_sel", ext_a, (v == 7));
    // R4 ramp duration and per-cycle step
    check(cycles >= n*CYC_A && cycles <= n*CYC_A + 10, "R4 ramp time", cycles, n*CYC_A);
    check(bad_a == 0, "R4 step bound", bad_a, 0);
    // R5 clamped landing and no overshoot with coarse step
    check(int'(dac_b) == t, "R5 clamped landing", dac_b, t);
    check(bad_b == 0, "R5 no overshoot", bad_b, 0);
  endtask

  initial begin
    int seq[10] = '{1, 2, 3, 4, 5, 6, 7, 0, 7, 6};
    int cycles, bad, prev_b, last_b;
    rst_n = 1'b0; vid = 3'd0; soft_start = 1'b0; run_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dac_a == 0 && done_a == 0 && ext_a == 0, "R1 during reset", dac_a, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    check(dac_a == 0 && done_a == 0 && ext_a == 0, "R1 after reset", dac_a, 0);

    // R7 run rises: start from 0, ramp to 3300
    @(negedge clk);
    run_en = 1'b1; #1;
    check(dac_a == 0, "R7 start at zero", dac_a, 0);
    cycles = 0; bad = 0; prev_b = 0; last_b = 0;
    while (cycles < 20000) begin
      @(negedge clk); #1;
      cycles++;
      if (dac_b != 12'(prev_b)) begin last_b = prev_b; prev_b = dac_b; end
      if (dac_a > 3300 || dac_b > 3300) bad++;
      if (done_a && done_b) break;
    end
    check(cycles >= 3300*CYC_A && cycles <= 3300*CYC_A + 2, "R4 startup time", cycles, 3300*CYC_A);
    check(dac_a == 3300, "R2 startup target", dac_a, 3300);
    check(bad == 0, "R5 startup no overshoot", bad, 0);
    check(dac_b == 3300 && last_b == 3297, "R5 final clamp step", last_b, 3297);

    // Sweep every ID, including transitions into and out of external mode
    foreach (seq[i]) go_vid(seq[i]);

    // R8 glitches of 3 and 2 cycles are ignored (now at ID 6, 800 mV)
    bad = 0;
    @(negedge clk); vid = 3'd5;
    repeat (3) @(negedge clk); vid = 3'd6;
    repeat (30) begin
      @(negedge clk); #1;
      if (dac_a != 800 || !done_a || ext_a) bad++;
    end
    @(negedge clk); vid = 3'd7;
    repeat (2) @(negedge clk); vid = 3'd6;
    repeat (30) begin
      @(negedge clk); #1;
      if (dac_a != 800 || !done_a || ext_a) bad++;
    end
    check(bad == 0, "R8 glitch ignored", bad, 0);

    // R6 soft-start pulse
    @(negedge clk); soft_start = 1'b1;
    @(negedge clk); soft_start = 1'b0; #1;
    check(dac_a == 0 && !done_a, "R6 code cleared", dac_a, 0);
    cycles = 0;
    while (cycles < 5000 && !done_a) begin @(negedge clk); #1; cycles++; end
    check(dac_a == 800 && cycles >= 800*CYC_A - 1 && cycles <= 800*CYC_A + 2,
          "R6 re-ramp time", cycles, 800*CYC_A);

    // R7 run low mid-ramp forces zero at once
    @(negedge clk); soft_start = 1'b1;
    @(negedge clk); soft_start = 1'b0;
    repeat (100) @(negedge clk);
    #1;
    check(dac_a > 0 && dac_a < 800, "R7 mid-ramp", dac_a, 50);
    run_en = 1'b0; #1;
    check(dac_a == 0 && !done_a, "R7 forced zero", dac_a, 0);
    repeat (5) @(negedge clk);
    #1;
    check(dac_a == 0, "R7 held zero", dac_a, 0);
    run_en = 1'b1;
    @(negedge clk); #1;
    check(dac_a <= 1, "R7 restart from zero", dac_a, 0);
    while (!done_a) @(negedge clk);
    #1;
    check(dac_a == 800 && done_a, "R9 done on target", dac_a, 800);

    report();
  end
endmodule